// File: doc/BRIEF.md
# Grouped INT4 Asymmetric Dot-Product Engine

This block reduces one output column of a 4-bit quantized weight matrix against an activation vector. Weights arrive as 32-bit words that each pack eight unsigned 4-bit values taken in reduction order. Each word comes with eight signed 16-bit activations. For every weight the block subtracts the zero-point of the weight's group, multiplies by the group's signed Q8.8 scale and by the matching activation, and adds the product into a wide accumulator.

Zero-points are themselves stored as 4-bit values, eight to a 32-bit word. The caller presents the zero-point word that holds the current group. The block derives the group index from its own running word count and picks the right nibble. Scale and zero-point are captured on the first word of each group. While they are not flagged valid, the block holds off that word. After the last word of the column, the block narrows the accumulator to the output width and raises a one-cycle completion flag.

Top module: `int4_group_dot`

## Requirements
- R1: After reset, `done` is 0, `result` is 0 and `w_ready` is 0.
- R2: A `start` pulse clears the accumulator and the word counter and makes the block busy. `start` wins over a word offered in the same cycle, and a start in the middle of a job discards the partial sum.
- R3: Weight lane i of `w_word` sits in bits [4i+3:4i] and pairs with activation lane i of `act_word` in bits [16i+15:16i]. Lane 0 is the first weight in reduction order.
- R4: Each weight w (unsigned 0..15) contributes (w − z) × scale × act. Here z is its group's zero-point (unsigned 0..15), scale is signed 16-bit with 8 fraction bits, and act is signed 16-bit.
- R5: The word with index p belongs to group g = 8p / GROUP_SIZE. Its zero-point is nibble g mod 8 of `zp_word`, in bits [4(g mod 8)+3 : 4(g mod 8)].
- R6: Scale and zero-point are captured only on the first word of a group. Changes on `scale`, `zp_word` or `grp_valid` while later words of that group are transferred have no effect on the result.
- R7: While busy, `w_ready` is 1 except on the first word of a group while `grp_valid` is 0.
- R8: `done` is high for exactly one cycle, in the cycle after word K_LEN/8 − 1 is transferred. `result` holds its value until the next job completes.
- R9: `result` equals the full-precision sum shifted right arithmetically by 8 bits and saturated to the signed OUT_W range.
- R10: When not busy, `w_ready` is 0 and offered words change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a new column; clears state |
| w_valid | input | 1 | Weight word and activations offered |
| w_ready | output | 1 | Block accepts the offered word |
| w_word | input | 32 | Eight packed unsigned 4-bit weights |
| act_word | input | 8*ACT_W | Eight signed activations, lane i at [16i+15:16i] |
| grp_valid | input | 1 | Scale and zero-point word are valid |
| scale | input | SCALE_W | Signed Q8.8 group scale |
| zp_word | input | 32 | Eight packed 4-bit zero-points |
| done | output | 1 | One-cycle completion pulse |
| result | output | OUT_W | Narrowed, saturated dot product |

## Verification
The first pattern is a ramp job. Each nibble, activation lane and group scale has a distinct value, so a swapped lane, a wrong zero-point nibble or an off-by-one group boundary each produce a different sum. A randomized job adds held-off group parameters and bubbles in the stream, and puts junk on the scale and zero-point ports between group starts; this separates latched parameters from live ones. Extreme values at full scale test positive and negative saturation. A job where every weight equals its zero-point must give exactly zero. A restart in the middle of a job shows whether the partial sum is cleared.

// File: rtl/int4dot_pkg.sv
package int4dot_pkg;
    localparam int NIB_W  = 4;
    localparam int LANES  = 8;
    localparam int WORD_W = NIB_W * LANES;
    localparam int DIFF_W = NIB_W + 2;
    localparam int SEL_W  = $clog2(LANES);
endpackage

// File: rtl/int4_nibble_pick.sv
module int4_nibble_pick
    import int4dot_pkg::*;
(
    input  logic [WORD_W-1:0] packed_word,
    input  logic [SEL_W-1:0]  sel,
    output logic [NIB_W-1:0]  nib
);
    always_comb begin
        nib = packed_word[sel*NIB_W +: NIB_W];
    end
endmodule

// File: rtl/int4_lane_mul.sv
module int4_lane_mul
    import int4dot_pkg::*;
#(
    parameter int ACT_W   = 16,
    parameter int SCALE_W = 16,
    parameter int PROD_W  = DIFF_W + SCALE_W + ACT_W
)(
    input  logic [NIB_W-1:0]   wq,
    input  logic [NIB_W-1:0]   zq,
    input  logic [SCALE_W-1:0] scale,
    input  logic [ACT_W-1:0]   act,
    output logic [PROD_W-1:0]  prod
);
    logic signed [DIFF_W-1:0] diff;
    logic signed [PROD_W-1:0] diff_x, scale_x, act_x;

    always_comb begin
        diff    = $signed({2'b00, wq}) - $signed({2'b00, zq});
        diff_x  = $signed({{(PROD_W-DIFF_W){diff[DIFF_W-1]}}, diff});
        scale_x = $signed({{(PROD_W-SCALE_W){scale[SCALE_W-1]}}, scale});
        act_x   = $signed({{(PROD_W-ACT_W){act[ACT_W-1]}}, act});
        prod    = diff_x * scale_x * act_x;
        // R4
        diff_range_chk: assert (diff >= -6'sd15 && diff <= 6'sd15);
    end
endmodule

// File: rtl/int4_word_dot.sv
module int4_word_dot
    import int4dot_pkg::*;
#(
    parameter int ACT_W   = 16,
    parameter int SCALE_W = 16,
    parameter int PROD_W  = DIFF_W + SCALE_W + ACT_W,
    parameter int SUM_W   = PROD_W + SEL_W
)(
    input  logic [WORD_W-1:0]      w_word,
    input  logic [NIB_W-1:0]       zq,
    input  logic [SCALE_W-1:0]     scale,
    input  logic [LANES*ACT_W-1:0] act_word,
    output logic [SUM_W-1:0]       sum
);
    logic [PROD_W-1:0] prod [LANES];

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        int4_lane_mul #(
            .ACT_W  (ACT_W),
            .SCALE_W(SCALE_W),
            .PROD_W (PROD_W)
        ) u_mul (
            .wq   (w_word[i*NIB_W +: NIB_W]),
            .zq   (zq),
            .scale(scale),
            .act  (act_word[i*ACT_W +: ACT_W]),
            .prod (prod[i])
        );
    end

    always_comb begin
        sum = '0;
        for (int i = 0; i < LANES; i++) begin
            sum = sum + {{(SUM_W-PROD_W){prod[i][PROD_W-1]}}, prod[i]};
        end
    end
endmodule

// File: rtl/int4_group_dot.sv
module int4_group_dot
    import int4dot_pkg::*;
#(
    parameter int K_LEN      = 256,
    parameter int GROUP_SIZE = 128,
    parameter int ACT_W      = 16,
    parameter int SCALE_W    = 16,
    parameter int FRAC_W     = 8,
    parameter int ACC_W      = 48,
    parameter int OUT_W      = 32
)(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic                   w_valid,
    output logic                   w_ready,
    input  logic [WORD_W-1:0]      w_word,
    input  logic [LANES*ACT_W-1:0] act_word,
    input  logic                   grp_valid,
    input  logic [SCALE_W-1:0]     scale,
    input  logic [WORD_W-1:0]      zp_word,
    output logic                   done,
    output logic [OUT_W-1:0]       result
);
    localparam int WORDS   = K_LEN / LANES;
    localparam int WPG     = GROUP_SIZE / LANES;
    localparam int LOG_WPG = $clog2(WPG);
    localparam int CNT_W   = $clog2(WORDS) + SEL_W + 1;
    localparam int PROD_W  = DIFF_W + SCALE_W + ACT_W;
    localparam int SUM_W   = PROD_W + SEL_W;
    localparam logic [ACC_W-1:0] SAT_HI = {{(ACC_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
    localparam logic [ACC_W-1:0] SAT_LO = {{(ACC_W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};

    typedef struct packed {
        logic               busy;
        logic [CNT_W-1:0]   widx;
        logic [ACC_W-1:0]   acc;
        logic [SCALE_W-1:0] scale;
        logic [NIB_W-1:0]   zp;
        logic               done;
        logic [OUT_W-1:0]   result;
    } state_t;

    state_t st_d, st_q;

    logic               first_w, last_w, accept;
    logic [SEL_W-1:0]   zsel;
    logic [NIB_W-1:0]   zp_nib, eff_zp;
    logic [SCALE_W-1:0] eff_scale;
    logic [SUM_W-1:0]   word_sum;
    logic [ACC_W-1:0]   acc_new, shifted, narrowed;

    int4_nibble_pick u_zpick (
        .packed_word(zp_word),
        .sel        (zsel),
        .nib        (zp_nib)
    );

    int4_word_dot #(
        .ACT_W  (ACT_W),
        .SCALE_W(SCALE_W),
        .PROD_W (PROD_W),
        .SUM_W  (SUM_W)
    ) u_dot (
        .w_word  (w_word),
        .zq      (eff_zp),
        .scale   (eff_scale),
        .act_word(act_word),
        .sum     (word_sum)
    );

    always_comb begin
        first_w   = (st_q.widx & CNT_W'(WPG - 1)) == '0;
        last_w    = st_q.widx == CNT_W'(WORDS - 1);
        zsel      = SEL_W'(st_q.widx >> LOG_WPG);
        eff_zp    = first_w ? zp_nib : st_q.zp;
        eff_scale = first_w ? scale  : st_q.scale;
        w_ready   = st_q.busy && !start && (!first_w || grp_valid);
        accept    = w_valid && w_ready;
        acc_new   = st_q.acc + {{(ACC_W-SUM_W){word_sum[SUM_W-1]}}, word_sum};
        shifted   = $signed(acc_new) >>> FRAC_W;
        if ($signed(shifted) > $signed(SAT_HI)) begin
            narrowed = SAT_HI;
        end else if ($signed(shifted) < $signed(SAT_LO)) begin
            narrowed = SAT_LO;
        end else begin
            narrowed = shifted;
        end

        st_d      = st_q;
        st_d.done = 1'b0;
        if (start) begin
            st_d.busy = 1'b1;
            st_d.widx = '0;
            st_d.acc  = '0;
        end else if (accept) begin
            st_d.acc  = acc_new;
            st_d.widx = st_q.widx + 1'b1;
            if (first_w) begin
                st_d.scale = scale;
                st_d.zp    = zp_nib;
            end
            if (last_w) begin
                st_d.busy   = 1'b0;
                st_d.done   = 1'b1;
                st_d.result = narrowed[OUT_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign done   = st_q.done;
    assign result = st_q.result;

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R8
    done_after_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(w_valid && w_ready));
    // R10
    idle_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |-> !w_ready);
    // R2
    start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (st_q.acc == '0 && st_q.widx == '0 && st_q.busy));
    // R6
    param_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (w_valid && w_ready && !first_w) |=> ($stable(st_q.scale) && $stable(st_q.zp)));
    // R8
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(result));
endmodule

// File: tb/sim_int4_group_dot.sv
module sim_int4_group_dot;
    localparam int CLK_PERIOD = 10;
    localparam int K_LEN  = 256;
    localparam int GROUP  = 16;
    localparam int WORDS  = K_LEN / 8;
    localparam int WPG    = GROUP / 8;
    localparam int GROUPS = K_LEN / GROUP;
    localparam int ZPW    = (GROUPS + 7) / 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic w_valid = 1'b0;
    logic w_ready;
    logic [31:0] w_word = '0;
    logic [127:0] act_word = '0;
    logic grp_valid = 1'b0;
    logic [15:0] scale = '0;
    logic [31:0] zp_word = '0;
    logic done;
    logic [31:0] result;

    int errs = 0;
    int checks = 0;
    string job_tag = "R1";

    logic [31:0] wm [WORDS];
    logic [15:0] am [WORDS][8];
    logic [15:0] sm [GROUPS];
    logic [31:0] zm [ZPW];

    // behavioural model state
    bit     m_busy = 0;
    int     m_cnt = 0;
    longint m_acc = 0;
    longint m_scale = 0;
    longint m_zp = 0;
    bit     m_done = 0;
    longint m_res = 0;

    int4_group_dot #(.K_LEN(K_LEN), .GROUP_SIZE(GROUP)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .w_valid(w_valid),
        .w_ready(w_ready), .w_word(w_word), .act_word(act_word),
        .grp_valid(grp_valid), .scale(scale), .zp_word(zp_word),
        .done(done), .result(result)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic bit model_ready();
        return m_busy && !start && (((m_cnt % WPG) != 0) || grp_valid);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_cnt = 0; m_acc = 0; m_done = 0; m_res = 0;
        end else begin
            bit rdy;
            rdy = model_ready();
            m_done = 0;
            if (start) begin
                m_busy = 1; m_cnt = 0; m_acc = 0;
            end else if (rdy && w_valid) begin
                if ((m_cnt % WPG) == 0) begin
                    int g;
                    g = (m_cnt * 8) / GROUP;
                    m_scale = longint'($signed(scale));
                    m_zp = longint'((zp_word >> (4 * (g % 8))) & 32'hF);
                end
                for (int i = 0; i < 8; i++) begin
                    longint wv, av;
                    wv = longint'((w_word >> (4 * i)) & 32'hF);
                    av = longint'($signed(act_word[16*i +: 16]));
                    m_acc = m_acc + (wv - m_zp) * m_scale * av;
                end
                m_cnt++;
                if (m_cnt == WORDS) begin
                    longint sh;
                    sh = m_acc >>> 8;
                    if (sh > 64'sd2147483647) sh = 64'sd2147483647;
                    if (sh < -64'sd2147483648) sh = -64'sd2147483648;
                    m_busy = 0; m_done = 1; m_res = sh;
                end
            end
        end
    end

    task automatic check(bit ok, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    bit mon_on = 0;
    always @(negedge clk) begin
        if (rst_n && mon_on) begin
            check(w_ready == model_ready(), "R7 R10 w_ready", w_ready, model_ready());
            check(done == m_done, {"R8 done ", job_tag}, done, m_done);
            check(longint'($signed(result)) == m_res, {"R9 result ", job_tag},
                  longint'($signed(result)), m_res);
        end
    end

    task automatic pulse_start();
        start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
    endtask

    // nwords words; hold: cycles grp_valid stays low at group start; gap: bubbles; junk: noise mid-group
    task automatic run_job(int nwords, int hold, int gap, bit junk);
        for (int p = 0; p < nwords; p++) begin
            int g, waits;
            g = (p * 8) / GROUP;
            w_word = wm[p];
            for (int i = 0; i < 8; i++) act_word[16*i +: 16] = am[p][i];
            w_valid = 1'b1;
            if ((p % WPG) == 0) begin
                scale = sm[g];
                zp_word = zm[g / 8];
                grp_valid = (hold == 0);
            end else if (junk) begin
                scale = 16'($urandom);
                zp_word = $urandom;
                grp_valid = 1'($urandom);
            end
            waits = 0;
            while (1) begin
                @(negedge clk);
                if (w_ready) break;
                @(posedge clk); #1;
                waits++;
                if (waits >= hold) grp_valid = 1'b1;
            end
            @(posedge clk); #1;
            w_valid = 1'b0;
            if (junk) begin
                w_word = $urandom;
                scale = 16'($urandom);
                zp_word = $urandom;
            end
            repeat (gap) begin @(posedge clk); #1; end
        end
        repeat (3) begin @(posedge clk); #1; end
    endtask

    task automatic make_job(int mode);
        for (int p = 0; p < WORDS; p++) begin
            for (int i = 0; i < 8; i++) begin
                case (mode)
                    0: begin
                        wm[p][4*i +: 4] = 4'((p + i) & 15);
                        am[p][i] = 16'((i + 1) * 100 - p * 3);
                    end
                    1: begin
                        wm[p][4*i +: 4] = 4'($urandom);
                        am[p][i] = 16'($urandom);
                    end
                    2: begin wm[p][4*i +: 4] = 4'hF; am[p][i] = 16'h7FFF; end
                    3: begin wm[p][4*i +: 4] = 4'hF; am[p][i] = 16'h8000; end
                    default: begin wm[p][4*i +: 4] = 4'h7; am[p][i] = 16'($urandom); end
                endcase
            end
        end
        for (int g = 0; g < GROUPS; g++) begin
            case (mode)
                0: sm[g] = 16'(g * 37 + 5);
                1: sm[g] = 16'($urandom);
                2, 3: sm[g] = 16'h7FFF;
                default: sm[g] = 16'($urandom);
            endcase
        end
        for (int z = 0; z < ZPW; z++) begin
            case (mode)
                0: zm[z] = (z == 0) ? 32'h76543210 : 32'hFEDCBA98;
                1: zm[z] = $urandom;
                2, 3: zm[z] = 32'h0;
                default: zm[z] = 32'h77777777;
            endcase
        end
    endtask

    initial begin
        int cyc;
        cyc = 0;
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                errs++;
                checks++;
                $display("FAIL watchdog all-requirements actual=%0d expected=<150000", cyc);
                $display("Result: errors=%0d of %0d checks", errs, checks);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(done == 1'b0, "R1 done after reset", done, 0);
        check(result == 32'h0, "R1 result after reset", result, 0);
        check(w_ready == 1'b0, "R1 w_ready after reset", w_ready, 0);
        @(posedge clk); #1;
        mon_on = 1;

        // R10: words offered while idle are refused and ignored
        job_tag = "R10 idle";
        w_valid = 1'b1; w_word = 32'hFFFFFFFF; grp_valid = 1'b1; scale = 16'h7FFF;
        repeat (4) begin @(posedge clk); #1; end
        w_valid = 1'b0;

        // R3 R4 R5: ramp job with distinct lanes, nibbles and scales
        job_tag = "R3 R4 R5 ramp";
        make_job(0); pulse_start(); run_job(WORDS, 0, 0, 0);

        // R6 R7: random data, held-off group params, bubbles, mid-group noise
        job_tag = "R6 R7 random";
        make_job(1); pulse_start(); run_job(WORDS, 3, 1, 1);

        // R9 positive saturation
        job_tag = "R9 sat-pos";
        make_job(2); pulse_start(); run_job(WORDS, 0, 0, 0);

        // R9 negative saturation
        job_tag = "R9 sat-neg";
        make_job(3); pulse_start(); run_job(WORDS, 1, 0, 0);

        // R4: weight equal to zero-point contributes nothing
        job_tag = "R4 zero";
        make_job(4); pulse_start(); run_job(WORDS, 0, 0, 1);

        // R2: restart in the middle of a job discards the partial sum
        job_tag = "R2 restart";
        make_job(1); pulse_start(); run_job(5, 0, 0, 0);
        make_job(0); pulse_start(); run_job(WORDS, 2, 0, 1);

        mon_on = 0;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule